// File: doc/BRIEF.md
# Pipelined Burst SRAM with Byte Lanes

This block is a synthesizable model of a synchronous static RAM. Its bus is pipelined so that read and write slots can follow each other on consecutive cycles with no idle cycle between them. Each enabled clock edge samples one command slot. A slot is one of three things: it loads a new address together with fresh read/write control, it advances the burst in progress to the next location of its four-location block, or it is an idle (deselected) slot.

Read data appears two enabled edges after its address slot. Write data is taken from the data input two enabled edges after its address slot. Both directions therefore use the data bus in the same pipeline position.

The burst order is chosen by a mode pin, either linear wrap or interleaved. Every beat of a write, single or burst, carries its own byte-lane mask. The shared bidirectional data bus is modelled as separate input and output ports plus an output-drive flag.

Top module: `pl_burst_sram`

## Requirements
- R1: A load slot (adv_i=0) selects the device only when sel0_ni=0, sel1_i=1 and sel2_ni=0 all hold. If any one of them is inactive, the slot is idle: nothing is read or written, and any burst in progress ends.
- R2: A write slot is a selected load with we_ni=0. Byte lane k (data bits 8k+7..8k) of the addressed word is updated only when bw_ni[k]=0. The other lanes keep their old contents.
- R3: Every beat of a burst write uses the bw_ni value sampled in its own slot. Different beats may therefore write different lane subsets.
- R4: With mode_i=0, beat k (k=0..3) of a burst loaded at address A accesses A with its two low bits replaced by (A[1:0]+k) mod 4.
- R5: With mode_i=1, beat k of a burst loaded at address A accesses A with its two low bits replaced by A[1:0] XOR k.
- R6: adv_i=0 loads the address and control. adv_i=1 steps the current burst and keeps its direction. An advance after an idle load is ignored.
- R7: Advances past the fourth beat keep wrapping within the same aligned four-word block, following the R4/R5 order.
- R8: Read data for a slot is on data_o after the second enabled edge following that slot. Write data for a slot is sampled from data_i at that same second edge. Alternating reads and writes need no idle slot, and a read issued in the slot after a write to the same word returns the new data.
- R9: While cke_ni=1, no state changes: data_o, data_oe_o, the memory and the burst position all hold, and data_i is ignored.
- R10: data_oe_o is 1 only when oe_ni=0 and the output stage holds a read beat. It is 0 for idle and write slots, and 0 after reset, with data_o reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_ni | input | 1 | Clock enable, active low |
| sel0_ni | input | 1 | Select, active low |
| sel1_i | input | 1 | Select, active high |
| sel2_ni | input | 1 | Select, active low |
| adv_i | input | 1 | 1 = advance burst, 0 = load new address |
| we_ni | input | 1 | Write enable on load, active low |
| bw_ni | input | 4 | Byte-lane write selects, active low |
| mode_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| oe_ni | input | 1 | Output enable, active low |
| addr_i | input | AW | Word address |
| data_i | input | 32 | Write data |
| data_o | output | 32 | Read data |
| data_oe_o | output | 1 | Output drive flag |

## Verification
The assertions assume that the control pins hold settled values at every enabled edge. They also assume that the output-enable and clock-enable inputs may change freely between edges, and that the address bus carries meaning only in load slots. The stimulus changes every input half a period away from the active edge and sends each command through one slot task. The slot task runs a bench-side burst address generator and byte-masked reference memory derived from R4 and R5, and it reads only words that an earlier write has already set. Clock-enable stalls are inserted while both read and write beats are inside the pipeline, and data_i is driven with garbage during those stalls.

// File: rtl/pl_burst_pkg.sv
package pl_burst_pkg;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned BEATS  = 4;

  // low address bits of a burst beat
  function automatic logic [1:0] beat_lo(input logic mode, input logic [1:0] start,
                                         input logic [1:0] cnt);
    return mode ? (start ^ cnt) : (start + cnt);
  endfunction
endpackage

// File: rtl/burst_seq.sv
module burst_seq
  import pl_burst_pkg::*;
#(
  parameter int unsigned AW    = 8,
  parameter int unsigned LANES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cke_i,
  input  logic             load_i,
  input  logic             sel_i,
  input  logic             wr_i,
  input  logic             mode_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [LANES-1:0] be_i,
  output logic             beat_vld_o,
  output logic             beat_wr_o,
  output logic [AW-1:0]    beat_addr_o,
  output logic [LANES-1:0] beat_be_o
);
  logic          act_q, wr_q;
  logic [AW-1:0] base_q;
  logic [1:0]    cnt_q, cnt_nx;

  always_comb begin
    beat_be_o = be_i;
    if (load_i) begin
      cnt_nx      = '0;
      beat_vld_o  = sel_i;
      beat_wr_o   = wr_i;
      beat_addr_o = addr_i;
    end else begin
      cnt_nx      = cnt_q + 2'd1;
      beat_vld_o  = act_q;
      beat_wr_o   = wr_q;
      beat_addr_o = {base_q[AW-1:2], beat_lo(mode_i, base_q[1:0], cnt_nx)};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
      base_q <= '0;
      cnt_q  <= '0;
    end else if (cke_i) begin
      if (load_i) begin
        act_q  <= sel_i;
        wr_q   <= wr_i;
        base_q <= addr_i;
        cnt_q  <= '0;
      end else if (act_q) begin
        cnt_q  <= cnt_nx;
      end
    end
  end

  // R7: an advancing beat stays in the block of the last load
  assert_blk_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cke_i && load_i && sel_i) ##1 (cke_i && !load_i)
      |-> beat_addr_o[AW-1:2] == $past(addr_i[AW-1:2]));
endmodule

// File: rtl/sram_bank.sv
module sram_bank
  import pl_burst_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned LANES = 4,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned DW   = LANES * LANE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cke_i,
  input  logic             vld_i,
  input  logic             wr_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [LANES-1:0] be_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic             rvld_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk_i)
      if (cke_i && vld_i && wr_i && be_i[g]) mem[addr_i] <= wdata_i[g*LANE_W +: LANE_W];

    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) rd_q <= '0;
      else if (cke_i && vld_i && !wr_i) rd_q <= mem[addr_i];

    assign rdata_o[g*LANE_W +: LANE_W] = rd_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) rvld_o <= 1'b0;
    else if (cke_i) rvld_o <= vld_i && !wr_i;

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_i |=> $stable(rdata_o) && $stable(rvld_o));
  assert_wr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cke_i && vld_i && wr_i) |=> !rvld_o && $stable(rdata_o));
endmodule

// File: rtl/pl_burst_sram.sv
module pl_burst_sram
  import pl_burst_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned LANES = 4,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned DW   = LANES * LANE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cke_ni,
  input  logic             sel0_ni,
  input  logic             sel1_i,
  input  logic             sel2_ni,
  input  logic             adv_i,
  input  logic             we_ni,
  input  logic [LANES-1:0] bw_ni,
  input  logic             mode_i,
  input  logic             oe_ni,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    data_i,
  output logic [DW-1:0]    data_o,
  output logic             data_oe_o
);
  typedef struct packed {
    logic             vld;
    logic             wr;
    logic [AW-1:0]    addr;
    logic [LANES-1:0] be;
  } slot_t;

  logic  cke, sel_all, rvld;
  slot_t beat, s1_q, s2_q;

  assign cke     = !cke_ni;
  assign sel_all = !sel0_ni && sel1_i && !sel2_ni;

  burst_seq #(.AW(AW), .LANES(LANES)) u_seq (
    .clk_i, .rst_ni,
    .cke_i      (cke),
    .load_i     (!adv_i),
    .sel_i      (sel_all),
    .wr_i       (!we_ni),
    .mode_i,
    .addr_i,
    .be_i       (~bw_ni),
    .beat_vld_o (beat.vld),
    .beat_wr_o  (beat.wr),
    .beat_addr_o(beat.addr),
    .beat_be_o  (beat.be)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else if (cke) begin
      s1_q <= beat;
      s2_q <= s1_q;
    end
  end

  sram_bank #(.DEPTH(DEPTH), .LANES(LANES)) u_bank (
    .clk_i, .rst_ni,
    .cke_i  (cke),
    .vld_i  (s2_q.vld),
    .wr_i   (s2_q.wr),
    .addr_i (s2_q.addr),
    .be_i   (s2_q.be),
    .wdata_i(data_i),
    .rdata_o(data_o),
    .rvld_o (rvld)
  );

  assign data_oe_o = rvld && !oe_ni;

  assert_desel_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cke && !adv_i && !sel_all) |=> !s1_q.vld);
  assert_ign_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cke && !adv_i && !sel_all) ##1 (cke && adv_i) |=> !s1_q.vld);
  assert_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cke && !adv_i && !sel_all) ##1 cke ##1 cke |-> ##0 1'b1 ##1 !data_oe_o);
  assert_lat_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cke && !adv_i && sel_all && we_ni) ##1 cke ##1 cke |=> (data_oe_o == !oe_ni));
endmodule

// File: tb/sim_pl_burst_sram.sv
module sim_pl_burst_sram;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 256;
  localparam int AW = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cke_ni = 1'b0, sel0_ni = 1'b1, sel1_i = 1'b0, sel2_ni = 1'b1, adv_i = 1'b0;
  logic we_ni = 1'b1, mode_i = 1'b0, oe_ni = 1'b0;
  logic [3:0]    bw_ni = 4'hf;
  logic [AW-1:0] addr_i = '0;
  logic [31:0]   data_i = '0, data_o;
  logic          data_oe_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  pl_burst_sram #(.DEPTH(DEPTH), .LANES(4)) u0 (
    .clk_i(clk), .rst_ni, .cke_ni, .sel0_ni, .sel1_i, .sel2_ni, .adv_i, .we_ni,
    .bw_ni, .mode_i, .oe_ni, .addr_i, .data_i, .data_o, .data_oe_o);

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [31:0] ref_mem [DEPTH];
  // bench burst generator and two-slot latency model
  logic b_act = 0, b_wr = 0;
  logic [AW-1:0] b_base = '0;
  logic [1:0] b_cnt = '0;
  logic p_vld [2], p_wr [2];
  logic [AW-1:0] p_addr [2];
  logic [3:0] p_be [2];
  string p_tag [2];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] wgen(input int c);
    return {8'(c), 8'(c*3+1), 8'(c ^ 8'h5a), 8'(c + 8'h77)};
  endfunction

  // one enabled slot; sels bit=1 means that enable active; be active-high lanes
  task automatic slot(input bit adv, input logic [AW-1:0] a, input bit wr,
                      input logic [3:0] be, input logic [2:0] sels, input bit oe, input string tag);
    logic n_vld, n_wr; logic [AW-1:0] n_addr; logic [31:0] wd;
    n_vld = 0; n_wr = wr; n_addr = a;
    if (!adv) begin
      n_vld = &sels; b_act = n_vld; b_wr = wr; b_base = a; b_cnt = 0;
    end else if (b_act) begin
      b_cnt = b_cnt + 1; n_vld = 1; n_wr = b_wr;
      n_addr = {b_base[AW-1:2], mode_i ? (b_base[1:0] ^ b_cnt) : (b_base[1:0] + b_cnt)};
    end
    wd = wgen(cyc);
    cke_ni = 0; adv_i = adv; addr_i = a; we_ni = !wr; bw_ni = ~be; oe_ni = !oe;
    sel0_ni = !sels[0]; sel1_i = sels[1]; sel2_ni = !sels[2]; data_i = wd;
    @(posedge clk); @(negedge clk);
    if (p_vld[1] && p_wr[1]) begin
      for (int k = 0; k < 4; k++)
        if (p_be[1][k]) ref_mem[p_addr[1]][k*8 +: 8] = wd[k*8 +: 8];
      chk(p_tag[1], {31'd0, data_oe_o}, 32'd0, "oe on write slot");
    end else if (p_vld[1]) begin
      chk(p_tag[1], data_o, ref_mem[p_addr[1]], "read data");
      chk(p_tag[1], {31'd0, data_oe_o}, {31'd0, oe}, "oe on read slot");
    end else begin
      chk(p_tag[1], {31'd0, data_oe_o}, 32'd0, "oe on idle slot");
    end
    p_vld[1] = p_vld[0]; p_wr[1] = p_wr[0]; p_addr[1] = p_addr[0]; p_be[1] = p_be[0]; p_tag[1] = p_tag[0];
    p_vld[0] = n_vld; p_wr[0] = n_wr; p_addr[0] = n_addr; p_be[0] = be; p_tag[0] = tag;
    cyc++;
  endtask

  task automatic ld(input logic [AW-1:0] a, input bit wr, input logic [3:0] be, input string tag);
    slot(0, a, wr, be, 3'b111, 1, tag);
  endtask
  task automatic nx(input logic [3:0] be, input string tag);
    slot(1, 8'hff, 0, be, 3'b000, 1, tag);
  endtask
  task automatic idle(input string tag);
    slot(0, 8'h00, 0, 4'h0, 3'b000, 1, tag);
  endtask
  task automatic flush(input string tag);
    idle(tag); idle(tag);
  endtask

  task automatic t_reset;
    chk("R10", data_o, 32'd0, "reset data_o");
    chk("R10", {31'd0, data_oe_o}, 32'd0, "reset oe");
  endtask

  task automatic t_fill;  // linear full-lane write bursts over words 0..63
    mode_i = 0;
    for (int b = 0; b < 16; b++) begin
      ld(8'(b*4), 1, 4'hf, "R4"); nx(4'hf, "R4"); nx(4'hf, "R4"); nx(4'hf, "R4");
    end
    flush("R4");
  endtask

  task automatic t_linear;
    mode_i = 0;
    ld(8'd5, 0, 4'h0, "R4"); nx(0, "R4"); nx(0, "R4"); nx(0, "R4");
    ld(8'd14, 1, 4'hf, "R4"); nx(4'hf, "R4"); nx(4'hf, "R4"); nx(4'hf, "R4");
    ld(8'd12, 0, 0, "R4"); nx(0, "R4"); nx(0, "R4"); nx(0, "R4");
    flush("R4");
  endtask

  task automatic t_interleave;
    mode_i = 1;
    ld(8'd18, 1, 4'hf, "R5"); nx(4'hf, "R5"); nx(4'hf, "R5"); nx(4'hf, "R5");
    ld(8'd16, 0, 0, "R5"); nx(0, "R5"); nx(0, "R5"); nx(0, "R5");
    ld(8'd19, 0, 0, "R5"); nx(0, "R5"); nx(0, "R5"); nx(0, "R5");
    flush("R5");
    mode_i = 0;
  endtask

  task automatic t_bytes;
    ld(8'd20, 1, 4'b0101, "R2"); ld(8'd21, 1, 4'b0000, "R2"); ld(8'd22, 1, 4'b1000, "R2");
    ld(8'd20, 0, 0, "R2"); ld(8'd21, 0, 0, "R2"); ld(8'd22, 0, 0, "R2");
    flush("R2");
  endtask

  task automatic t_burst_bytes;
    mode_i = 1;
    ld(8'd25, 1, 4'b0001, "R3"); nx(4'b0010, "R3"); nx(4'b1100, "R3"); nx(4'b0000, "R3");
    ld(8'd24, 0, 0, "R3"); nx(0, "R3"); nx(0, "R3"); nx(0, "R3");
    flush("R3");
    mode_i = 0;
  endtask

  task automatic t_select;
    slot(0, 8'd30, 1, 4'hf, 3'b110, 1, "R1");
    slot(0, 8'd30, 1, 4'hf, 3'b101, 1, "R1");
    slot(0, 8'd30, 1, 4'hf, 3'b011, 1, "R1");
    slot(0, 8'd31, 0, 4'h0, 3'b011, 1, "R1");
    nx(4'hf, "R1");
    ld(8'd30, 0, 0, "R1");
    flush("R1");
  endtask

  task automatic t_adv_ign;
    ld(8'd33, 1, 4'hf, "R6");
    idle("R6"); nx(4'hf, "R6"); nx(4'hf, "R6"); nx(4'hf, "R6");
    ld(8'd32, 0, 0, "R6"); nx(0, "R6"); nx(0, "R6"); nx(0, "R6");
    flush("R6");
  endtask

  task automatic t_wrap;
    for (int m = 0; m < 2; m++) begin
      mode_i = m[0];
      ld(8'd42, 0, 0, "R7");
      for (int i = 0; i < 7; i++) nx(0, "R7");
      ld(8'd41, 1, 4'hf, "R7");
      for (int i = 0; i < 5; i++) nx(4'hf, "R7");
      ld(8'd40, 0, 0, "R7"); nx(0, "R7"); nx(0, "R7"); nx(0, "R7");
      flush("R7");
    end
    mode_i = 0;
  endtask

  task automatic t_pingpong;
    for (int i = 0; i < 6; i++) begin
      ld(8'(44 + i), 1, 4'hf, "R8");
      ld(8'(44 + i), 0, 0, "R8");
      ld(8'(50 - i), 0, 0, "R8");
    end
    flush("R8");
  endtask

  task automatic stall(input int n, input string tag);
    logic [31:0] d0; logic o0;
    d0 = data_o; o0 = data_oe_o;
    for (int i = 0; i < n; i++) begin
      cke_ni = 1; adv_i = i[0]; we_ni = 0; bw_ni = 0; addr_i = 8'(60 + i);
      sel0_ni = 0; sel1_i = 1; sel2_ni = 0; data_i = 32'hdead_0000 | i;
      @(posedge clk); @(negedge clk);
      chk(tag, data_o, d0, "held data_o");
      chk(tag, {31'd0, data_oe_o}, {31'd0, o0}, "held oe");
    end
  endtask

  task automatic t_cke;
    ld(8'd52, 0, 0, "R9"); nx(0, "R9");
    ld(8'd57, 1, 4'hf, "R9"); nx(4'hf, "R9");
    stall(3, "R9");
    nx(4'hf, "R9"); stall(2, "R9"); nx(4'hf, "R9");
    ld(8'd56, 0, 0, "R9"); nx(0, "R9"); stall(2, "R9"); nx(0, "R9"); nx(0, "R9");
    flush("R9");
  endtask

  task automatic t_oe;
    slot(0, 8'd8, 0, 0, 3'b111, 0, "R10");
    slot(1, 8'd0, 0, 0, 3'b000, 0, "R10");
    slot(1, 8'd0, 0, 0, 3'b000, 1, "R10");
    idle("R10"); flush("R10");
  endtask

  bit done = 0;
  initial begin
    for (int i = 0; i < 2; i++) begin p_vld[i] = 0; p_wr[i] = 0; p_addr[i] = '0; p_be[i] = '0; p_tag[i] = "R10"; end
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    t_reset(); t_fill(); t_linear(); t_interleave(); t_bytes(); t_burst_bytes();
    t_select(); t_adv_ign(); t_wrap(); t_pingpong(); t_cke(); t_oe();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule